// File: doc/BRIEF.md
# I2C Register-File Target with Pointer Auto-Increment

This block is a target on a two-wire I2C bus. It gives a bus master read and write access to a byte-wide register file that lives in the host logic. The block oversamples SCL and SDA with the system clock through a synchronizer. It finds START and STOP conditions, and it pulls SDA low through an open-drain enable (`sda_oe` high means the line is pulled low). The seven-bit bus address has a fixed upper part, the parameter `ADDR_HI`. Its lowest bit comes from the `addr_lsb` strap, so two copies can share one bus.

A write transaction carries the address byte, then one pointer byte, then any number of data bytes. Each data byte goes to the pointer, and the pointer then steps up by one. A read begins with an address byte whose R/W bit is 1, usually after a repeated START that follows a pointer byte. The block returns bytes from the pointer and advances the pointer after each one. The read continues while the master acknowledges and ends on a NACK.

The host side is a plain register port with single-cycle write and read strobes. The block does not stretch the clock, so it applies no back-pressure. The host must accept every write strobe and must return `rf_rdata` for `rf_addr` combinationally in the cycle of the read strobe.

Top module: `i2c_regfile_target`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sda_oe` is 0 and no strobe is issued. The pointer resets to 0.
- R2: The address byte is `{ADDR_HI, addr_lsb, rw}`, sent MSB first. `ADDR_HI` defaults to 6'b110000, so the byte is 0xC0/0xC2 to write and 0xC1/0xC3 to read. On a match the block acknowledges (SDA low) during the ninth SCL pulse. `sda_oe` changes only while SCL is low.
- R3: When the address does not match, SDA stays released for the whole transaction, including later bytes, and no register access takes place.
- R4: The first byte after a matching write address loads the pointer (its low `AW` bits), is acknowledged, and is not written.
- R5: Each later data byte is acknowledged and written to the pointer with one `rf_wr_en` strobe. The pointer then increases by one.
- R6: The pointer wraps from 2^AW-1 to 0, for both writes and reads.
- R7: After a START with R/W=1, the block sends the byte at the current pointer MSB first, and the pointer increases by one per byte sent.
- R8: When the master acknowledges a read byte, the next byte follows. When the master NACKs, SDA stays released until the next START.
- R9: With a 50 MHz system clock, the block works at both 100 kbit/s and 400 kbit/s.
- R10: The pointer holds across STOP, so a read that has no pointer byte continues where the last transfer left off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| addr_lsb | input | 1 | Strap for the lowest bus address bit |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| rf_addr | output | AW | Register pointer, used as the address for both strobes |
| rf_wr_en | output | 1 | Single-cycle write strobe |
| rf_wdata | output | 8 | Byte to write, valid with `rf_wr_en` |
| rf_rd_en | output | 1 | Single-cycle read strobe; `rf_rdata` is taken in this cycle |
| rf_rdata | input | 8 | Host read data for `rf_addr` |

## Verification
Every reaction of the block comes three system cycles after the SCL edge that causes it: two synchronizer stages, then one state register. An ACK or a new read bit therefore appears on SDA three cycles after an SCL fall. A write strobe follows three cycles after the fall that ends the eighth data bit. The bench samples SDA for ACK and read bits in the middle of the high phase of SCL, at least 32 system cycles after the preceding fall. It checks register contents and write counts only after STOP, when every strobe has already landed.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } tgt_state_e;

  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '1;
        else     chain[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '1;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2c_rf_cond.sv
module i2c_rf_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s && !scl_p;
  assign scl_fall  = !scl_s && scl_p;
  assign start_det = scl_s && scl_p && sda_p && !sda_s;
  assign stop_det  = scl_s && scl_p && !sda_p && sda_s;
endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
  import i2c_rf_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b110000,
  parameter int         AW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_lsb,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rf_rdata,
  output logic          sda_oe,
  output logic [AW-1:0] rf_addr,
  output logic          rf_wr_en,
  output logic [7:0]    rf_wdata,
  output logic          rf_rd_en
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_BITS - 1);

  tgt_state_e       state;
  logic [7:0]       shreg;
  logic [CNT_W-1:0] bitcnt;
  logic [AW-1:0]    ptr;
  logic             rw_q, oe_q, wr_q, rd_q, mack_q;
  logic [7:0]       wdata_q;
  logic             rx_state;

  assign rx_state = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      ptr     <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      wdata_q <= '0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (wr_q) ptr <= ptr + 1'b1;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        oe_q   <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        oe_q  <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise && bitcnt != LAST_RX) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall && bitcnt == LAST_RX) begin
          bitcnt <= '0;
          if (state == ST_ADDR) begin
            if (shreg[7:1] == {ADDR_HI, addr_lsb}) begin
              rw_q  <= shreg[0];
              oe_q  <= 1'b1;
              state <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end else if (state == ST_PTR) begin
            ptr   <= shreg[AW-1:0];
            oe_q  <= 1'b1;
            state <= ST_PTR_ACK;
          end else begin
            wr_q    <= 1'b1;
            wdata_q <= shreg;
            oe_q    <= 1'b1;
            state   <= ST_WDATA_ACK;
          end
        end
      end else begin
        case (state)
          ST_ADDR_ACK: if (scl_fall) begin
            oe_q   <= 1'b0;
            bitcnt <= '0;
            if (rw_q) begin
              rd_q  <= 1'b1;
              state <= ST_RDATA;
            end else begin
              state <= ST_PTR;
            end
          end
          ST_PTR_ACK, ST_WDATA_ACK: if (scl_fall) begin
            oe_q   <= 1'b0;
            bitcnt <= '0;
            state  <= ST_WDATA;
          end
          ST_RDATA: begin
            if (rd_q) begin
              shreg <= rf_rdata;
              oe_q  <= !rf_rdata[7];
              ptr   <= ptr + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == LAST_TX) begin
                oe_q   <= 1'b0;
                bitcnt <= '0;
                state  <= ST_RDATA_ACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                oe_q   <= !shreg[6];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise) mack_q <= !sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                rd_q  <= 1'b1;
                state <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe   = oe_q;
  assign rf_addr  = ptr;
  assign rf_wr_en = wr_q;
  assign rf_wdata = wdata_q;
  assign rf_rd_en = rd_q;
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter logic [5:0] ADDR_HI     = 6'b110000,
  parameter int         AW          = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          addr_lsb,
  output logic          sda_oe,
  output logic [AW-1:0] rf_addr,
  output logic          rf_wr_en,
  output logic [7:0]    rf_wdata,
  output logic          rf_rd_en,
  input  logic [7:0]    rf_rdata
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_rf_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o ({scl_s, sda_s})
  );

  i2c_rf_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rf_engine #(.ADDR_HI(ADDR_HI), .AW(AW)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .addr_lsb  (addr_lsb),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rf_rdata  (rf_rdata),
    .sda_oe    (sda_oe),
    .rf_addr   (rf_addr),
    .rf_wr_en  (rf_wr_en),
    .rf_wdata  (rf_wdata),
    .rf_rd_en  (rf_rd_en)
  );
endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          rf_wr_en,
  input logic          rf_rd_en,
  input logic [AW-1:0] rf_addr
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sda_oe && !rf_wr_en && !rf_rd_en)); // R1

  AST_OE_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R2

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |=> !rf_wr_en); // R5

  AST_PTR_STEP_WRITE: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |=> (rf_addr == AW'($past(rf_addr) + 1'b1))); // R6

  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rf_rd_en |=> !rf_rd_en); // R7

  AST_PTR_STEP_READ: assert property (@(posedge clk) disable iff (rst)
    rf_rd_en |=> (rf_addr == AW'($past(rf_addr) + 1'b1))); // R7

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rf_wr_en && rf_rd_en)); // R5
endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe),
  .rf_wr_en (rf_wr_en),
  .rf_rd_en (rf_rd_en),
  .rf_addr  (rf_addr)
);

// File: tb/i2c_regfile_target_test.sv
module i2c_regfile_target_test;
  localparam int CLK_PERIOD = 20;
  localparam int AW = 4;
  localparam int NREG = 1 << AW;
  localparam int Q_FAST = 32;
  localparam int Q_STD  = 125;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl_low = 1'b0;
  logic m_sda_low = 1'b0;
  logic addr_lsb = 1'b0;
  logic sda_oe, rf_wr_en, rf_rd_en;
  logic [AW-1:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  logic scl_line, sda_line;
  logic [7:0] regs [NREG];
  int wr_count;
  int vectors = 0;
  int miscompares = 0;
  int q_cur = Q_FAST;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = !m_scl_low;
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_regfile_target #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line), .addr_lsb(addr_lsb),
    .sda_oe(sda_oe), .rf_addr(rf_addr), .rf_wr_en(rf_wr_en), .rf_wdata(rf_wdata),
    .rf_rd_en(rf_rd_en), .rf_rdata(rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'(8'hA0 + i);
      wr_count <= 0;
    end else if (rf_wr_en) begin
      regs[rf_addr] <= rf_wdata;
      wr_count <= wr_count + 1;
    end
  end
  assign rf_rdata = regs[rf_addr];

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 0; m_scl_low = 0; wq(q_cur);
    m_sda_low = 1; wq(q_cur);
    m_scl_low = 1; wq(q_cur);
  endtask

  task automatic bus_rstart();
    m_sda_low = 0; wq(q_cur);
    m_scl_low = 0; wq(q_cur);
    m_sda_low = 1; wq(q_cur);
    m_scl_low = 1; wq(q_cur);
  endtask

  task automatic bus_stop();
    m_sda_low = 1; wq(q_cur);
    m_scl_low = 0; wq(q_cur);
    m_sda_low = 0; wq(q_cur);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i]; wq(q_cur);
      m_scl_low = 0; wq(2*q_cur);
      m_scl_low = 1; wq(q_cur);
    end
    m_sda_low = 0; wq(q_cur);
    m_scl_low = 0; wq(q_cur);
    nack = sda_line; wq(q_cur);
    m_scl_low = 1; wq(q_cur);
  endtask

  task automatic get_byte(input logic master_ack, output logic [7:0] b);
    m_sda_low = 0;
    for (int i = 7; i >= 0; i--) begin
      wq(q_cur);
      m_scl_low = 0; wq(q_cur);
      b[i] = sda_line; wq(q_cur);
      m_scl_low = 1; wq(q_cur);
    end
    m_sda_low = master_ack; wq(q_cur);
    m_scl_low = 0; wq(2*q_cur);
    m_scl_low = 1; wq(q_cur);
    m_sda_low = 0;
  endtask

  task automatic t_reset();
    rst = 1; wq(5);
    chk("R1 sda_oe in reset", sda_oe, 0);
    chk("R1 wr strobe in reset", rf_wr_en, 0);
    rst = 0; wq(5);
    chk("R1 pointer after reset", rf_addr, 0);
  endtask

  task automatic t_wrong_addr();
    logic nk; int w0;
    addr_lsb = 0; w0 = wr_count;
    bus_start();
    put_byte(8'hC2, nk); chk("R3 mismatched address not acked", nk, 1);
    put_byte(8'h05, nk); chk("R3 later byte not acked", nk, 1);
    put_byte(8'h3C, nk); chk("R3 data byte not acked", nk, 1);
    bus_stop();
    chk("R3 no write on mismatch", wr_count, w0);
  endtask

  task automatic t_burst_write();
    logic nk; int w0;
    w0 = wr_count;
    bus_start();
    put_byte(8'hC0, nk); chk("R2 address ack", nk, 0);
    put_byte(8'h03, nk); chk("R4 pointer byte ack", nk, 0);
    put_byte(8'h11, nk); chk("R5 data ack", nk, 0);
    put_byte(8'h22, nk); chk("R5 data ack", nk, 0);
    put_byte(8'h33, nk); chk("R5 data ack", nk, 0);
    bus_stop();
    chk("R4 pointer byte not written", wr_count - w0, 3);
    chk("R5 reg3", regs[3], 8'h11);
    chk("R5 reg4", regs[4], 8'h22);
    chk("R5 reg5", regs[5], 8'h33);
    chk("R5 reg2 untouched", regs[2], 8'hA2);
    chk("R5 reg6 untouched", regs[6], 8'hA6);
  endtask

  task automatic t_read();
    logic nk; logic [7:0] b;
    bus_start();
    put_byte(8'hC0, nk);
    put_byte(8'h03, nk);
    bus_rstart();
    put_byte(8'hC1, nk); chk("R7 read address ack", nk, 0);
    get_byte(1'b1, b); chk("R7 first read byte", b, 8'h11);
    get_byte(1'b1, b); chk("R8 byte after master ack", b, 8'h22);
    get_byte(1'b0, b); chk("R7 third read byte", b, 8'h33);
    wq(8);
    chk("R8 SDA released after NACK", sda_oe, 0);
    bus_stop();
    bus_start();
    put_byte(8'hC1, nk); chk("R10 read without pointer ack", nk, 0);
    get_byte(1'b0, b); chk("R10 read continues at pointer", b, 8'hA6);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic nk; logic [7:0] b;
    bus_start();
    put_byte(8'hC0, nk);
    put_byte(8'h0F, nk);
    put_byte(8'h5A, nk);
    put_byte(8'h5B, nk);
    bus_stop();
    chk("R6 write at last register", regs[15], 8'h5A);
    chk("R6 write wrapped to zero", regs[0], 8'h5B);
    bus_start();
    put_byte(8'hC0, nk);
    put_byte(8'h0F, nk);
    bus_rstart();
    put_byte(8'hC1, nk);
    get_byte(1'b1, b); chk("R6 read last register", b, 8'h5A);
    get_byte(1'b0, b); chk("R6 read wrapped to zero", b, 8'h5B);
    bus_stop();
  endtask

  task automatic t_strap();
    logic nk;
    addr_lsb = 1;
    bus_start();
    put_byte(8'hC0, nk); chk("R3 strap=1 rejects 0xC0", nk, 1);
    bus_stop();
    bus_start();
    put_byte(8'hC2, nk); chk("R2 strap=1 accepts 0xC2", nk, 0);
    put_byte(8'h08, nk);
    put_byte(8'h77, nk);
    bus_stop();
    chk("R2 write with strap=1", regs[8], 8'h77);
    addr_lsb = 0;
  endtask

  task automatic t_slow();
    logic nk; logic [7:0] b;
    q_cur = Q_STD;
    bus_start();
    put_byte(8'hC0, nk); chk("R9 100k address ack", nk, 0);
    put_byte(8'h09, nk);
    put_byte(8'h9C, nk);
    bus_rstart();
    put_byte(8'hC0, nk);
    put_byte(8'h09, nk);
    bus_rstart();
    put_byte(8'hC1, nk);
    get_byte(1'b0, b); chk("R9 100k read back", b, 8'h9C);
    bus_stop();
    chk("R9 100k register", regs[9], 8'h9C);
    q_cur = Q_FAST;
  endtask

  initial begin
    t_reset();
    t_wrong_addr();
    t_burst_write();
    t_read();
    t_wrap();
    t_strap();
    t_slow();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule